// File: doc/BRIEF.md
# Duty-Cycle Offset Correction Loop

This block closes the digital half of a receiver offset-cancellation loop. Each frame it receives two sample words. Both words hold values of the recovered clock. One word was captured on rising data transitions and the other on falling data transitions. An amplifier offset widens one data level at the expense of the other, so one word collects more ones than its partner. The block counts the ones in both words and registers a vote for the direction of correction.

Votes are heavily decimated before they reach the output. Each direction has its own prescaler counter, and only a prescaler wrap moves the correction code by one step. The code is a saturating up/down value that feeds an external DAC, which biases the amplifier. The decimation keeps the loop bandwidth far below that of clock recovery. Other logic can also step the same code through a pair of request inputs.

Top module: `dcc_offset_loop`

## Requirements
- R1: While `rst_n` is low at a clock edge, the code is set to mid-scale 2^(CODE_W-1) (64 by default) and both prescalers are cleared to zero.
- R2: A frame presented with `frame_valid_i` high before clock edge k is voted on at edge k. Any code step that results from that vote appears at edge k+1.
- R3: A valid frame whose falling-edge word has more ones than its rising-edge word is an increment vote. The reverse is a decrement vote. Equal counts give no vote.
- R4: The increment prescaler advances once per increment vote. Every 2^PRESCALE_W-th increment vote since reset raises the code by one.
- R5: The decrement prescaler advances once per decrement vote. Every 2^PRESCALE_W-th decrement vote since reset lowers the code by one.
- R6: The two prescalers are independent. Votes in one direction neither clear nor advance the other prescaler.
- R7: The code saturates. An up step at 2^CODE_W-1 (127) and a down step at 0 leave it unchanged.
- R8: `ext_inc_i` or `ext_dec_i` high before an edge steps the code by one at that edge.
- R9: In a cycle with both an up request (internal wrap or external) and a down request, the code holds. Several up requests, or several down requests, in one cycle give a single step.
- R10: While `frame_valid_i` is low, the sample words are ignored. No vote is formed and no prescaler advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid_i | input | 1 | Qualifies both sample words for this cycle |
| rise_smp_i | input | WORD_W | Clock samples taken on rising data transitions |
| fall_smp_i | input | WORD_W | Clock samples taken on falling data transitions |
| ext_inc_i | input | 1 | External request to step the code up |
| ext_dec_i | input | 1 | External request to step the code down |
| code_o | output | CODE_W | Correction code to the DAC |

## Verification
The only visible state is the code. A prescaler that has drifted or been cleared wrongly shows up as a step that lands on the wrong vote, and it surfaces only at the next wrap, up to 2^PRESCALE_W votes later. The bench therefore runs with a short prescaler and tracks both counts in a model, checking the code every cycle. Wrong vote timing or a wrong vote polarity shows up one cycle early or late, or as a step in the wrong direction. Saturation and cancellation faults appear on the edge right after the request.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   localparam int DIR_UP = 0;
   localparam int DIR_DN = 1;
   localparam int N_DIR  = 2;

   function automatic int ones_width(input int w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/dcc_popcount.sv
module dcc_popcount #(
   parameter int W  = 16,
   parameter int CW = dcc_pkg::ones_width(W)
) (
   input  logic [W-1:0]  bits_i,
   output logic [CW-1:0] ones_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dcc_popcount: W must be at least 1");
      end
      if (W == 1) begin : g_single
         assign ones_o = CW'(bits_i[0]);
      end else begin : g_sum
         always_comb begin
            ones_o = '0;
            for (int i = 0; i < W; i++) begin
               ones_o = ones_o + CW'(bits_i[i]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dcc_vote.sv
module dcc_vote #(
   parameter int WORD_W   = 16,
   parameter bit REG_VOTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [WORD_W-1:0] rise_i,
   input  logic [WORD_W-1:0] fall_i,
   output logic              vote_up_o,
   output logic              vote_dn_o
);
   localparam int CW = dcc_pkg::ones_width(WORD_W);

   logic [CW-1:0] rise_ones, fall_ones;
   logic          up_d, dn_d;

   dcc_popcount #(.W(WORD_W)) u_cnt_rise (.bits_i(rise_i), .ones_o(rise_ones));
   dcc_popcount #(.W(WORD_W)) u_cnt_fall (.bits_i(fall_i), .ones_o(fall_ones));

   assign up_d = valid_i && (fall_ones > rise_ones);
   assign dn_d = valid_i && (rise_ones > fall_ones);

   generate
      if (REG_VOTE) begin : g_reg
         logic up_q, dn_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               up_q <= 1'b0;
               dn_q <= 1'b0;
            end else begin
               up_q <= up_d;
               dn_q <= dn_d;
            end
         end
         assign vote_up_o = up_q;
         assign vote_dn_o = dn_q;
      end else begin : g_comb
         assign vote_up_o = up_d;
         assign vote_dn_o = dn_d;
      end
   endgenerate
endmodule

// File: rtl/dcc_prescaler.sv
module dcc_prescaler #(
   parameter int CNT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   output logic tick_o
);
   logic [CNT_W-1:0] cnt;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("dcc_prescaler: CNT_W must be at least 1");
      end
   endgenerate

   assign tick_o = adv_i && (cnt == {CNT_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (adv_i) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dcc_code_ctr.sv
module dcc_code_ctr #(
   parameter int CODE_W    = 7,
   parameter int N_REQ     = 2,
   parameter int RESET_VAL = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REQ-1:0]  up_req_i,
   input  logic [N_REQ-1:0]  dn_req_i,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_VAL);

   generate
      if (RESET_VAL < 0 || RESET_VAL >= (1 << CODE_W)) begin : g_bad_rst
         $error("dcc_code_ctr: RESET_VAL outside code range");
      end
   endgenerate

   logic up_any, dn_any;
   assign up_any = |up_req_i;
   assign dn_any = |dn_req_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_o <= CODE_RST;
      end else if (up_any && !dn_any && (code_o != CODE_MAX)) begin
         code_o <= code_o + 1'b1;
      end else if (dn_any && !up_any && (code_o != '0)) begin
         code_o <= code_o - 1'b1;
      end
   end
endmodule

// File: rtl/dcc_offset_loop.sv
module dcc_offset_loop #(
   parameter int WORD_W     = 16,
   parameter int PRESCALE_W = 16,
   parameter int CODE_W     = 7,
   parameter bit REG_VOTE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid_i,
   input  logic [WORD_W-1:0] rise_smp_i,
   input  logic [WORD_W-1:0] fall_smp_i,
   input  logic              ext_inc_i,
   input  logic              ext_dec_i,
   output logic [CODE_W-1:0] code_o
);
   import dcc_pkg::*;

   localparam int CODE_MID = 1 << (CODE_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("dcc_offset_loop: WORD_W must be at least 2");
      end
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code
         $error("dcc_offset_loop: CODE_W must lie in 2..16");
      end
   endgenerate

   logic             vote_up, vote_dn;
   logic [N_DIR-1:0] adv, tick;
   logic             tick_up, tick_dn;

   dcc_vote #(.WORD_W(WORD_W), .REG_VOTE(REG_VOTE)) u_vote (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (frame_valid_i),
      .rise_i    (rise_smp_i),
      .fall_i    (fall_smp_i),
      .vote_up_o (vote_up),
      .vote_dn_o (vote_dn)
   );

   assign adv[DIR_UP] = vote_up;
   assign adv[DIR_DN] = vote_dn;

   generate
      for (genvar d = 0; d < N_DIR; d++) begin : g_pre
         dcc_prescaler #(.CNT_W(PRESCALE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (adv[d]),
            .tick_o (tick[d])
         );
      end
   endgenerate

   assign tick_up = tick[DIR_UP];
   assign tick_dn = tick[DIR_DN];

   dcc_code_ctr #(.CODE_W(CODE_W), .N_REQ(2), .RESET_VAL(CODE_MID)) u_code (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_req_i ({ext_inc_i, tick_up}),
      .dn_req_i ({ext_dec_i, tick_dn}),
      .code_o   (code_o)
   );
endmodule

// File: rtl/dcc_offset_loop_chk.sv
module dcc_offset_loop_chk #(
   parameter int CODE_W   = 7,
   parameter bit REG_VOTE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_valid_i,
   input logic              ext_inc_i,
   input logic              ext_dec_i,
   input logic [CODE_W-1:0] code_o,
   input logic              vote_up,
   input logic              vote_dn,
   input logic              tick_up,
   input logic              tick_dn
);
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));

   logic up_any, dn_any;
   assign up_any = ext_inc_i || tick_up;
   assign dn_any = ext_dec_i || tick_dn;

   // R1
   p_reset_mid_r1: assert property (@(posedge clk) !rst_n |=> code_o == CODE_MID);

   // R3
   p_vote_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vote_up, vote_dn}));

   // R4, R5: a wrap needs at least two votes
   p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_up |=> !tick_up);
   p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_dn |=> !tick_dn);

   // R7
   p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o == CODE_MAX && !dn_any) |=> code_o == CODE_MAX);
   p_sat_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o == '0 && !up_any) |=> code_o == '0);

   // R8
   p_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      up_any && !dn_any && code_o != CODE_MAX |=>
         {1'b0, code_o} == {1'b0, $past(code_o)} + 1'b1);
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !up_any && !dn_any |=> $stable(code_o));

   // R9
   p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      up_any && dn_any |=> $stable(code_o));

   // R10
   generate
      if (REG_VOTE) begin : g_reg_chk
         p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_valid_i |=> !vote_up && !vote_dn);
      end
   endgenerate
endmodule

bind dcc_offset_loop dcc_offset_loop_chk #(.CODE_W(CODE_W), .REG_VOTE(REG_VOTE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_valid_i (frame_valid_i),
   .ext_inc_i     (ext_inc_i),
   .ext_dec_i     (ext_dec_i),
   .code_o        (code_o),
   .vote_up       (vote_up),
   .vote_dn       (vote_dn),
   .tick_up       (tick_up),
   .tick_dn       (tick_dn)
);

// File: tb/tb_dcc_offset_loop.sv
module tb_dcc_offset_loop;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 16;
   localparam int PRESCALE_W = 3;
   localparam int CODE_W     = 7;
   localparam int PRE_MAX    = (1 << PRESCALE_W) - 1;
   localparam int CODE_TOP   = (1 << CODE_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_valid_i = 1'b0;
   logic [WORD_W-1:0] rise_smp_i = '0;
   logic [WORD_W-1:0] fall_smp_i = '0;
   logic              ext_inc_i = 1'b0;
   logic              ext_dec_i = 1'b0;
   logic [CODE_W-1:0] code_o;

   int checks = 0;
   int failures = 0;

   logic [CODE_W-1:0] exp_q[$];
   string             tag_q[$];

   int m_code = 64, m_up = 0, m_dn = 0;
   bit pend_up = 0, pend_dn = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dcc_offset_loop #(.WORD_W(WORD_W), .PRESCALE_W(PRESCALE_W), .CODE_W(CODE_W)) dut (
      .clk(clk), .rst_n(rst_n), .frame_valid_i(frame_valid_i),
      .rise_smp_i(rise_smp_i), .fall_smp_i(fall_smp_i),
      .ext_inc_i(ext_inc_i), .ext_dec_i(ext_dec_i), .code_o(code_o)
   );

   // driver: applies one cycle of stimulus and pushes the expected code
   task automatic step(input bit v, input logic [WORD_W-1:0] r, input logic [WORD_W-1:0] f,
                       input bit inc, input bit dec, input string tag);
      bit t_up, t_dn, up, dn;
      @(negedge clk);
      frame_valid_i = v; rise_smp_i = r; fall_smp_i = f;
      ext_inc_i = inc; ext_dec_i = dec;
      t_up = pend_up && (m_up == PRE_MAX);
      t_dn = pend_dn && (m_dn == PRE_MAX);
      if (pend_up) m_up = (m_up + 1) % (PRE_MAX + 1);
      if (pend_dn) m_dn = (m_dn + 1) % (PRE_MAX + 1);
      up = t_up || inc;
      dn = t_dn || dec;
      if (up && !dn && m_code < CODE_TOP) m_code++;
      else if (dn && !up && m_code > 0) m_code--;
      pend_up = v && ($countones(f) > $countones(r));
      pend_dn = v && ($countones(r) > $countones(f));
      exp_q.push_back(CODE_W'(m_code));
      tag_q.push_back(tag);
   endtask

   task automatic frames(input int n, input bit v, input logic [WORD_W-1:0] r,
                         input logic [WORD_W-1:0] f, input string tag);
      for (int i = 0; i < n; i++) step(v, r, f, 1'b0, 1'b0, tag);
   endtask

   // monitor: compares each result just after the edge that produces it
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [CODE_W-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (code_o !== e) begin
            failures++;
            $display("FAIL %s code actual=%0d expected=%0d", t, code_o, e);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      failures++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (code_o !== 7'd64) begin
         failures++;
         $display("FAIL R1 reset code actual=%0d expected=64", code_o);
      end
      rst_n = 1'b1;

      // R10: invalid frames with strong imbalance are ignored
      frames(20, 1'b0, 16'h0000, 16'hFFFF, "R10");
      frames(20, 1'b0, 16'hFFFF, 16'h0000, "R10");
      // R3: balanced valid frames give no vote
      frames(20, 1'b1, 16'hA5A5, 16'h5A5A, "R3");
      frames(12, 1'b1, 16'h00FF, 16'hF00F, "R3");
      // R4: falling word heavier -> up steps every 8 votes
      frames(8, 1'b1, 16'h000F, 16'h00FF, "R4");
      frames(16, 1'b1, 16'hA5A5, 16'h5A5B, "R4");
      // R5: rising word heavier -> down steps
      frames(8, 1'b1, 16'hFFFF, 16'h7FFF, "R5");
      frames(9, 1'b1, 16'h0F0F, 16'h0003, "R5");
      // R6: interleaved directions keep separate counts
      frames(5, 1'b1, 16'h0001, 16'h0003, "R6");
      frames(5, 1'b1, 16'h0007, 16'h0003, "R6");
      frames(3, 1'b1, 16'h0001, 16'h0003, "R6");
      frames(6, 1'b1, 16'h0007, 16'h0003, "R6");
      // R2: single-frame latency, alternating and gapped frames
      for (int i = 0; i < 20; i++) begin
         step(1'b1, 16'h0000, 16'h0101, 1'b0, 1'b0, "R2");
         step(1'b0, 16'h0000, 16'h0101, 1'b0, 1'b0, "R2");
      end
      // R8: external single steps
      step(1'b0, '0, '0, 1'b1, 1'b0, "R8");
      step(1'b0, '0, '0, 1'b0, 1'b0, "R8");
      step(1'b0, '0, '0, 1'b0, 1'b1, "R8");
      step(1'b0, '0, '0, 1'b0, 1'b1, "R8");
      // R9: simultaneous requests cancel; merged same-direction requests step once
      step(1'b0, '0, '0, 1'b1, 1'b1, "R9");
      step(1'b0, '0, '0, 1'b1, 1'b1, "R9");
      for (int i = 0; i < 24; i++) step(1'b1, 16'h0000, 16'h0001, 1'b1, 1'b0, "R9");
      for (int i = 0; i < 24; i++) step(1'b1, 16'h0001, 16'h0000, 1'b1, 1'b0, "R9");
      for (int i = 0; i < 24; i++) step(1'b1, 16'h0001, 16'h0000, 1'b0, 1'b1, "R9");
      // R7: saturate at top then at bottom
      for (int i = 0; i < 80; i++) step(1'b1, 16'h0000, 16'h0003, 1'b1, 1'b0, "R7");
      for (int i = 0; i < 150; i++) step(1'b1, 16'h0003, 16'h0000, 1'b0, 1'b1, "R7");
      frames(20, 1'b1, 16'h0003, 16'h0000, "R7");

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule